// File: doc/BRIEF.md
# Floating-Point Enabled Exception Gate

This block sits between a floating-point unit's exception summary flag and the program-interrupt logic. It decides when a raised floating-point exception turns into an interrupt request, which instruction address the handler will see, and whether the syndrome bit that marks an imprecise report must be set. A two-bit enable field from the machine state picks the delivery style. Zero masks the request but keeps the exception pending. Both bits set deliver precisely. Either single bit delivers imprecisely, after a programmable number of retired instructions.

When the exception is first seen, the gate records the address of the instruction that raised it. It then holds the request until the interrupt logic acknowledges it. If the exception was held back while masked, the request is raised as soon as software enables any delivery style. That late delivery always reports the current next-to-retire address and always sets the imprecise-indicator bit.

Top module: `fpx_gate`

## Requirements
- R1: While the synchronous active-low reset `rstN` is low, `intReq`, `savedAddr` and `impBit` are all 0 at the next clock edge.
- R2: An edge where `fexSummary` is 1 and no exception is pending or requested captures `causeAddr` and makes an exception pending. While an exception is pending or requested, further `fexSummary` pulses are ignored and never change the recorded causing address.
- R3: With `enMode` = 2'b11 and no earlier masking, `intReq` rises at the first edge after capture. At that point `savedAddr` equals the captured causing address and `impBit` is 0.
- R4: With `enMode` = 2'b01 or 2'b10, the request is raised at the first edge where the number of retired instructions counted since capture is at least `deferCount` (0 to 7). `savedAddr` then takes the `nextAddr` value present at that edge.
- R5: In the imprecise modes, `impBit` is 1 exactly when the delivered `savedAddr` differs from the causing address. A `deferCount` of 0 delivers the causing address with `impBit` = 0.
- R6: While `enMode` = 2'b00 the pending exception never raises `intReq`, and it stays pending.
- R7: An exception that was pending under `enMode` = 2'b00 is delivered at the first edge where `enMode` is non-zero, including 2'b11. It reports the `nextAddr` present at that edge with `impBit` = 1.
- R8: Once raised, `intReq`, `savedAddr` and `impBit` hold steady until an edge with `intAck` = 1. After that edge `intReq` is 0 and a new exception can be captured.
- R9: The deferral counter advances only on edges where `retireValid` is 1. Edges without a retirement do not bring an imprecise delivery closer.
- R10: A reset asserted while an exception is pending discards it, so no request follows after reset even with `enMode` = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| fexSummary | input | 1 | Floating-point exception summary flag |
| enMode | input | 2 | Delivery mode: 00 masked, 01/10 imprecise, 11 precise |
| deferCount | input | CNT_W (3) | Retired instructions to wait in the imprecise modes |
| causeAddr | input | ADDR_W (32) | Address of the instruction that raised the summary flag |
| retireValid | input | 1 | One instruction retires at this edge |
| nextAddr | input | ADDR_W (32) | Address of the next instruction to retire |
| intAck | input | 1 | Interrupt logic accepts the request |
| intReq | output | 1 | Program interrupt request |
| savedAddr | output | ADDR_W (32) | Address the handler should save |
| impBit | output | 1 | Imprecise indicator for the syndrome register |

## Verification
The assertions assume that `intAck` is only meaningful while `intReq` is high. They also assume software clears `fexSummary` before it acknowledges, so the same exception is not captured twice. The stimulus pulses `fexSummary` for one cycle at capture, and a second time with a different address to test that the capture is ignored. It raises `intAck` only after the request has been seen and held for an extra cycle. The random part draws the mode, the deferral, the masked duration and the `nextAddr` values, and sometimes forces `nextAddr` to equal the causing address so the no-mismatch case of the indicator is covered.

// File: rtl/fpx_gate_pkg.sv
package fpx_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_REQ  = 2'd2
  } gateState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;       // record cause address, reset counter
    logic countUp;       // one retirement counted
    logic clear;         // request acknowledged
    logic deliverCause;  // report causing address, indicator 0
    logic deliverNext;   // report next-to-retire address
    logic forceImp;      // indicator forced to 1 (late unmask)
  } gateStrobe_t;

  localparam logic [1:0] MODE_MASKED  = 2'b00;
  localparam logic [1:0] MODE_PRECISE = 2'b11;

endpackage

// File: rtl/fpx_gate_ctrl.sv
module fpx_gate_ctrl
  import fpx_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fexSummary,
  input  logic [1:0]  enMode,
  input  logic        retireValid,
  input  logic        intAck,
  input  logic        cntReached,
  input  logic        cntZero,
  output gateStrobe_t strobe,
  output logic        intReq
);

  gateState_t state, stateNext;
  logic wasMasked, wasMaskedNext;

  always_comb begin
    strobe        = '0;
    stateNext     = state;
    wasMaskedNext = wasMasked;
    unique case (state)
      ST_IDLE: begin
        if (fexSummary) begin
          strobe.capture = 1'b1;
          wasMaskedNext  = 1'b0;
          stateNext      = ST_PEND;
        end
      end
      ST_PEND: begin
        if (enMode == MODE_MASKED) begin
          wasMaskedNext = 1'b1;
        end else if (wasMasked) begin
          strobe.deliverNext = 1'b1;
          strobe.forceImp    = 1'b1;
          stateNext          = ST_REQ;
        end else if (enMode == MODE_PRECISE) begin
          strobe.deliverCause = 1'b1;
          stateNext           = ST_REQ;
        end else if (cntReached) begin
          if (cntZero) strobe.deliverCause = 1'b1;
          else         strobe.deliverNext  = 1'b1;
          stateNext = ST_REQ;
        end else if (retireValid) begin
          strobe.countUp = 1'b1;
        end
      end
      ST_REQ: begin
        if (intAck) begin
          strobe.clear  = 1'b1;
          wasMaskedNext = 1'b0;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wasMasked <= 1'b0;
    end else begin
      state     <= stateNext;
      wasMasked <= wasMaskedNext;
    end
  end

  assign intReq = (state == ST_REQ);

  // R6: masked mode never produces a request
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && enMode == MODE_MASKED) |=> !intReq);

  // R8: request held until acknowledged, then dropped
  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> intReq);

  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> !intReq);

  // R2: a summary flag seen while idle opens a pending exception
  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && fexSummary) |=> (state == ST_PEND));

endmodule

// File: rtl/fpx_gate_dpath.sv
module fpx_gate_dpath
  import fpx_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] causeAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [CNT_W-1:0]  deferCount,
  output logic              cntReached,
  output logic              cntZero,
  output logic [ADDR_W-1:0] savedAddr,
  output logic              impBit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] causeReg;
  logic [CNT_W-1:0]  retireCnt;

  assign cntReached = (retireCnt >= deferCount);
  assign cntZero    = (retireCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeReg  <= '0;
      retireCnt <= '0;
      savedAddr <= '0;
      impBit    <= 1'b0;
    end else begin
      if (strobe.capture) causeReg <= causeAddr;

      if (strobe.capture || strobe.clear)             retireCnt <= '0;
      else if (strobe.countUp && retireCnt != CNT_MAX) retireCnt <= retireCnt + 1'b1;

      if (strobe.deliverCause) begin
        savedAddr <= causeReg;
        impBit    <= 1'b0;
      end else if (strobe.deliverNext) begin
        savedAddr <= nextAddr;
        impBit    <= strobe.forceImp || (nextAddr != causeReg);
      end
    end
  end

  // R2: cause address only moves on a capture strobe
  p_cause_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(causeReg));

  // R3: precise report carries the causing address, indicator clear
  p_precise_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deliverCause |=> (savedAddr == causeReg && !impBit));

  // R5: indicator tracks address mismatch on an ordinary imprecise report
  p_imp_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.deliverNext && !strobe.forceImp) |=> (impBit == (savedAddr != causeReg)));

  // R7: late unmask always flags imprecise
  p_masked_imp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.deliverNext && strobe.forceImp) |=> impBit);

  // R9: counter moves only on a counted retirement, capture or clear
  p_count_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.countUp || strobe.capture || strobe.clear) |=> $stable(retireCnt));

endmodule

// File: rtl/fpx_gate.sv
module fpx_gate
  import fpx_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fexSummary,
  input  logic [1:0]        enMode,
  input  logic [CNT_W-1:0]  deferCount,
  input  logic [ADDR_W-1:0] causeAddr,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic              intAck,
  output logic              intReq,
  output logic [ADDR_W-1:0] savedAddr,
  output logic              impBit
);

  gateStrobe_t strobe;
  logic cntReached, cntZero;

  fpx_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fexSummary (fexSummary),
    .enMode     (enMode),
    .retireValid(retireValid),
    .intAck     (intAck),
    .cntReached (cntReached),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .intReq     (intReq)
  );

  fpx_gate_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .causeAddr  (causeAddr),
    .nextAddr   (nextAddr),
    .deferCount (deferCount),
    .cntReached (cntReached),
    .cntZero    (cntZero),
    .savedAddr  (savedAddr),
    .impBit     (impBit)
  );

  // R1 / R10: reset leaves no request and no indicator
  p_reset_clear_r10: assert property (@(posedge clk)
    !rstN |=> (!intReq && !impBit && savedAddr == '0));

endmodule

// File: tb/fpx_gate_tb.sv
module fpx_gate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fexSummary;
  logic [1:0]  enMode;
  logic [2:0]  deferCount;
  logic [31:0] causeAddr;
  logic        retireValid;
  logic [31:0] nextAddr;
  logic        intAck;
  logic        intReq;
  logic [31:0] savedAddr;
  logic        impBit;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_gate u_dut (
    .clk(clk), .rstN(rstN), .fexSummary(fexSummary), .enMode(enMode),
    .deferCount(deferCount), .causeAddr(causeAddr), .retireValid(retireValid),
    .nextAddr(nextAddr), .intAck(intAck), .intReq(intReq),
    .savedAddr(savedAddr), .impBit(impBit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Edge (counted from the one after capture) where the request appears
  function automatic int expEdge(int maskCycles, logic [1:0] mode, logic [2:0] d);
    if (maskCycles > 0)   return maskCycles + 1;
    if (mode == 2'b11)    return 1;
    return int'(d) + 1;
  endfunction

  function automatic logic [31:0] expAddr(int maskCycles, logic [1:0] mode, logic [2:0] d,
                                          logic [31:0] c, logic [31:0] nAt);
    if (maskCycles > 0)            return nAt;
    if (mode == 2'b11 || d == 0)   return c;
    return nAt;
  endfunction

  function automatic logic expImp(int maskCycles, logic [1:0] mode, logic [2:0] d,
                                  logic [31:0] c, logic [31:0] nAt);
    if (maskCycles > 0)            return 1'b1;
    if (mode == 2'b11 || d == 0)   return 1'b0;
    return (nAt != c);
  endfunction

  task automatic ackAndCheck(input string req);
    logic [31:0] held;
    held        = savedAddr;
    fexSummary  = 1'b0;
    retireValid = 1'($urandom);
    nextAddr    = $urandom;
    @(negedge clk);
    chk(intReq == 1'b1 && savedAddr == held, "R8", "request held without ack",
        savedAddr, held);
    intAck = 1'b1;
    @(negedge clk);
    chk(intReq == 1'b0, "R8", {"request dropped after ack ", req}, 32'(intReq), 32'd0);
    intAck = 1'b0;
  endtask

  task automatic runCase(input int maskCycles, input logic [1:0] mode, input logic [2:0] d,
                         input logic [31:0] c, input bit forceEq, input string req);
    int e;
    bit early;
    logic [31:0] nAt;
    e = expEdge(maskCycles, mode, d);
    early = 1'b0;
    nAt = '0;
    fexSummary  = 1'b1;
    causeAddr   = c;
    enMode      = (maskCycles > 0) ? 2'b00 : mode;
    deferCount  = d;
    retireValid = 1'b1;
    nextAddr    = $urandom;
    intAck      = 1'b0;
    @(negedge clk);
    for (int k = 1; k <= e; k++) begin
      if (intReq) early = 1'b1;
      fexSummary = (k == 1);
      causeAddr  = (k == 1) ? ~c : c;   // R2: second pulse must be ignored
      enMode     = (k <= maskCycles) ? 2'b00 : mode;
      nextAddr   = (forceEq && k == e) ? c : $urandom;
      if (k == e) nAt = nextAddr;
      @(negedge clk);
    end
    chk(!early, (maskCycles > 0) ? "R6" : req, "no request before due edge",
        32'(early), 32'd0);
    chk(intReq == 1'b1, req, "request raised on due edge", 32'(intReq), 32'd1);
    chk(savedAddr == expAddr(maskCycles, mode, d, c, nAt), req, "saved address (R2 R4)",
        savedAddr, expAddr(maskCycles, mode, d, c, nAt));
    chk(impBit == expImp(maskCycles, mode, d, c, nAt), req, "imprecise indicator (R5)",
        32'(impBit), 32'(expImp(maskCycles, mode, d, c, nAt)));
    ackAndCheck(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a3;
    void'($urandom(32'd20240611));
    rstN = 1'b0; fexSummary = 1'b0; enMode = 2'b00; deferCount = '0;
    causeAddr = '0; retireValid = 1'b0; nextAddr = '0; intAck = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(intReq == 0 && savedAddr == 0 && impBit == 0, "R1", "reset state",
        {savedAddr[30:0], intReq | impBit}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    runCase(0, 2'b11, 3'd5, 32'h0000_1000, 1'b0, "R3");
    runCase(0, 2'b01, 3'd0, 32'h0000_2000, 1'b0, "R5");
    runCase(0, 2'b10, 3'd7, 32'h0000_3000, 1'b0, "R4");
    runCase(0, 2'b01, 3'd3, 32'h0000_4000, 1'b1, "R5");
    runCase(3, 2'b11, 3'd0, 32'h0000_5000, 1'b0, "R7");
    runCase(2, 2'b01, 3'd4, 32'h0000_6000, 1'b1, "R7");

    // R9: no retirements, no progress toward delivery
    fexSummary = 1'b1; causeAddr = 32'h0000_7000; enMode = 2'b01;
    deferCount = 3'd2; retireValid = 1'b0;
    @(negedge clk);
    fexSummary = 1'b0;
    repeat (5) @(negedge clk);
    chk(intReq == 1'b0, "R9", "no delivery without retirements", 32'(intReq), 32'd0);
    retireValid = 1'b1;
    repeat (2) @(negedge clk);
    chk(intReq == 1'b0, "R9", "still waiting after two retirements", 32'(intReq), 32'd0);
    a3 = 32'h0000_7abc;
    nextAddr = a3;
    @(negedge clk);
    chk(intReq == 1'b1 && savedAddr == a3, "R9", "delivery after counted retirements",
        savedAddr, a3);
    ackAndCheck("R9");

    // R10: reset discards a pending exception
    fexSummary = 1'b1; causeAddr = 32'h0000_8000; enMode = 2'b00; retireValid = 1'b0;
    @(negedge clk);
    fexSummary = 1'b0; rstN = 1'b0;
    @(negedge clk);
    chk(intReq == 1'b0, "R10", "no request during reset", 32'(intReq), 32'd0);
    rstN = 1'b1; enMode = 2'b11;
    repeat (3) @(negedge clk);
    chk(intReq == 1'b0, "R10", "pending discarded by reset", 32'(intReq), 32'd0);

    // Constrained random mix
    for (int i = 0; i < 60; i++) begin
      int m;
      logic [1:0] md;
      logic [2:0] dd;
      m  = ($urandom % 4 == 0) ? 1 + int'($urandom % 5) : 0;
      md = 2'(1 + ($urandom % 3));
      dd = 3'($urandom % 8);
      runCase(m, md, dd, $urandom, ($urandom % 4) == 0,
              (m > 0) ? "R7" : (md == 2'b11) ? "R3" : "R4");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule